// File: doc/BRIEF.md
# Segment Selector Privilege Checker

This block turns a 16-bit segment selector into a descriptor address in one of two descriptor tables, fetches the 8-byte descriptor, and decides whether the requesting code may use the segment. It holds one base/limit register pair for the global table and one for the local table. System code at privilege level 0 loads these pairs through a load port, and any caller can read them back.

A request carries a selector and the current privilege level. The block checks that the whole descriptor lies inside the chosen table's limit. It then reads the descriptor as two 32-bit words over a level-held memory request with a single-cycle response strobe. It ends with a one-cycle done pulse that carries either a grant or one fault kind, together with the assembled descriptor. Only one request is in flight at a time: `req_ready` is high only while the block is idle.

Top module: `seg_priv_check`

## Requirements
- R1: After reset both table bases and limits read back as zero, `req_ready` is 1, `done` is 0 and `mem_req` is 0.
- R2: A load with `ld_cpl` equal to 0 writes `ld_base` and `ld_limit` into the local table when `ld_local` is 1 and into the global table when it is 0. `rd_base` and `rd_limit` show the table chosen by `rd_local`, and `ld_fault` is 0 in the cycle after the load.
- R3: A load with `ld_cpl` other than 0 leaves both tables unchanged and raises `ld_fault` for the single cycle after the load.
- R4: Selector bit 2 picks the local table (1) or the global table (0), and selector bits 15:3 form the index. The first read goes to base + index*8 and the second to that address + 4. `mem_addr` holds steady while `mem_req` waits for `mem_rvalid`.
- R5: When index*8 + 7 is greater than the chosen table's limit, the request completes with `fault_limit` and issues no memory read. `desc` is then zero.
- R6: `desc[31:0]` is the first word read and `desc[63:32]` is the second word.
- R7: The descriptor privilege level is `desc[46:45]`, and the requestor level is selector bits 1:0. The access is granted only when the current level is no larger than the descriptor level and the larger of the requestor and descriptor levels is also no larger than the descriptor level. Otherwise `fault_priv` is raised.
- R8: For a global-table descriptor with `desc[44]` = 0 and `desc[42:41]` = 2'b11 (an interrupt or trap gate), `fault_gate` is raised and takes priority over the privilege decision. The same pattern from the local table raises no gate fault.
- R9: `done` lasts one cycle, and exactly one of `granted`, `fault_limit`, `fault_gate` and `fault_priv` is high with it. All four are low when `done` is low. `req_ready` is low while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Table register load strobe |
| ld_local | input | 1 | Load target: 1 local, 0 global |
| ld_cpl | input | 2 | Privilege level of the loading code |
| ld_base | input | 32 | Base to load |
| ld_limit | input | 16 | Limit to load |
| ld_fault | output | 1 | Rejected-load pulse, one cycle after the load |
| rd_local | input | 1 | Readback select: 1 local, 0 global |
| rd_base | output | 32 | Readback base |
| rd_limit | output | 16 | Readback limit |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Idle, accepting a request |
| req_sel | input | 16 | Segment selector |
| req_cpl | input | 2 | Current privilege level |
| mem_req | output | 1 | Memory read request, held until mem_rvalid |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result pulse |
| granted | output | 1 | Access granted |
| fault_limit | output | 1 | Descriptor outside table limit |
| fault_gate | output | 1 | Gate descriptor in global table |
| fault_priv | output | 1 | Privilege check failed |
| desc | output | 64 | Fetched descriptor |

## Verification
A wrong stored base or limit shows at the readback port at once and in the memory address of the next fetch. A wrong limit comparison shows at the next request as a read that should not happen or a fault that should not occur. A swapped or lost descriptor word shows in `desc` and usually in the grant decision on the same done pulse. A sequencer stuck in a fetch state shows as `done` never arriving or `req_ready` staying low. The bench models memory with random response latency and predicts every read address, read count, descriptor and result flag.

// File: rtl/seg_priv_check.sv
module seg_priv_check #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  input  logic          ld_local,
  input  logic [1:0]    ld_cpl,
  input  logic [AW-1:0] ld_base,
  input  logic [LW-1:0] ld_limit,
  output logic          ld_fault,
  input  logic          rd_local,
  output logic [AW-1:0] rd_base,
  output logic [LW-1:0] rd_limit,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [LW-1:0] req_sel,
  input  logic [1:0]    req_cpl,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          done,
  output logic          granted,
  output logic          fault_limit,
  output logic          fault_gate,
  output logic          fault_priv,
  output logic [63:0]   desc
);
  localparam int IXW = LW - 3;

  typedef enum logic [1:0] {S_IDLE, S_RD_LO, S_RD_HI, S_CHECK} st_t;
  st_t st;

  logic [AW-1:0] gbase, lbase, addr_q;
  logic [LW-1:0] glimit, llimit;
  logic [LW-1:0] sel_q;
  logic [1:0]    cpl_q;
  logic          lim_fail_q;
  logic [63:0]   desc_q;

  logic          sel_local;
  logic [AW-1:0] cur_base;
  logic [LW-1:0] cur_limit, offset;
  logic          over;
  logic          accept;

  assign sel_local = req_sel[2];
  assign cur_base  = sel_local ? lbase : gbase;
  assign cur_limit = sel_local ? llimit : glimit;
  assign offset    = {req_sel[LW-1:3], 3'b000};
  assign over      = ({1'b0, offset} + (LW+1)'(7)) > {1'b0, cur_limit};
  assign accept    = req_valid && (st == S_IDLE);

  assign rd_base  = rd_local ? lbase : gbase;
  assign rd_limit = rd_local ? llimit : glimit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gbase    <= '0;
      lbase    <= '0;
      glimit   <= '0;
      llimit   <= '0;
      ld_fault <= 1'b0;
    end else begin
      ld_fault <= ld_valid && (ld_cpl != 2'd0);
      if (ld_valid && ld_cpl == 2'd0) begin
        if (ld_local) begin
          lbase  <= ld_base;
          llimit <= ld_limit;
        end else begin
          gbase  <= ld_base;
          glimit <= ld_limit;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      addr_q     <= '0;
      sel_q      <= '0;
      cpl_q      <= '0;
      lim_fail_q <= 1'b0;
      desc_q     <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          sel_q      <= req_sel;
          cpl_q      <= req_cpl;
          addr_q     <= cur_base + AW'(offset);
          lim_fail_q <= over;
          desc_q     <= '0;
          st         <= over ? S_CHECK : S_RD_LO;
        end
        S_RD_LO: if (mem_rvalid) begin
          desc_q[31:0] <= mem_rdata;
          st           <= S_RD_HI;
        end
        S_RD_HI: if (mem_rvalid) begin
          desc_q[63:32] <= mem_rdata;
          st            <= S_CHECK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_RD_LO) || (st == S_RD_HI);
  assign mem_addr  = (st == S_RD_HI) ? addr_q + AW'(4) : addr_q;

  logic [1:0] dpl, rpl, epl;
  logic       gate_hit, priv_ok;
  assign dpl      = desc_q[46:45];
  assign rpl      = sel_q[1:0];
  assign epl      = (rpl > dpl) ? rpl : dpl;
  assign gate_hit = !sel_q[2] && !desc_q[44] && (desc_q[42:41] == 2'b11);
  assign priv_ok  = (cpl_q <= dpl) && (epl <= dpl);

  assign done        = (st == S_CHECK);
  assign fault_limit = done && lim_fail_q;
  assign fault_gate  = done && !lim_fail_q && gate_hit;
  assign fault_priv  = done && !lim_fail_q && !gate_hit && !priv_ok;
  assign granted     = done && !lim_fail_q && !gate_hit && priv_ok;
  assign desc        = desc_q;
endmodule

module seg_priv_check_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_valid,
  input logic [1:0]    ld_cpl,
  input logic          ld_fault,
  input logic          req_ready,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rvalid,
  input logic          done,
  input logic          granted,
  input logic          fault_limit,
  input logic          fault_gate,
  input logic          fault_priv
);
  AST_LD_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_cpl == 2'd0 |=> !ld_fault); // R2
  AST_LD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_cpl != 2'd0 |=> ld_fault); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R4
  AST_LIMIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fault_limit |-> !$past(mem_req)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones({granted, fault_limit, fault_gate, fault_priv}) == 1); // R9
  AST_QUIET_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(granted || fault_limit || fault_gate || fault_priv)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || done) |-> !req_ready); // R9
endmodule

bind seg_priv_check seg_priv_check_sva #(.AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_cpl(ld_cpl),
  .ld_fault(ld_fault), .req_ready(req_ready), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .done(done),
  .granted(granted), .fault_limit(fault_limit), .fault_gate(fault_gate),
  .fault_priv(fault_priv)
);

// File: tb/sim_seg_priv_check.sv
`timescale 1ns/1ps
module sim_seg_priv_check;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        ld_valid = 0, ld_local = 0;
  logic [1:0]  ld_cpl = 0;
  logic [31:0] ld_base = 0;
  logic [15:0] ld_limit = 0;
  logic        ld_fault;
  logic        rd_local = 0;
  logic [31:0] rd_base;
  logic [15:0] rd_limit;
  logic        req_valid = 0, req_ready;
  logic [15:0] req_sel = 0;
  logic [1:0]  req_cpl = 0;
  logic        mem_req, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic        done, granted, fault_limit, fault_gate, fault_priv;
  logic [63:0] desc;

  seg_priv_check u0 (.*);

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [31:0] m_base [2];
  logic [15:0] m_limit [2];
  logic [31:0] salt = 32'h1357_9bdf;
  bit          force_hi_en = 0;
  logic [31:0] force_hi = 0;
  int          rd_count = 0;
  logic [31:0] rec0 = 0, rec1 = 0;
  int          wait_n = 0;

  function automatic logic [31:0] mw(input logic [31:0] a, input bit hi);
    if (hi && force_hi_en) return force_hi;
    return (a * 32'h2545_F491) ^ salt;
  endfunction

  always @(negedge clk) begin
    if (mem_rvalid) begin
      mem_rvalid <= 1'b0;
      wait_n <= $urandom % 3;
    end else if (mem_req) begin
      if (wait_n == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mw(mem_addr, rec0 + 4 == mem_addr && rd_count % 2 == 1);
        rec1 <= rec0;
        rec0 <= mem_addr;
        rd_count <= rd_count + 1;
      end else wait_n <= wait_n - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_load(input bit loc, input logic [31:0] b, input logic [15:0] l, input logic [1:0] c);
    @(negedge clk);
    ld_valid = 1; ld_local = loc; ld_base = b; ld_limit = l; ld_cpl = c;
    @(negedge clk);
    ld_valid = 0;
    chk(ld_fault == (c != 0), c != 0 ? "R3 ld_fault" : "R2 ld_fault", 64'(ld_fault), 64'(c != 0));
    if (c == 0) begin m_base[loc] = b; m_limit[loc] = l; end
    for (int t = 0; t < 2; t++) begin
      rd_local = t[0];
      #0.1;
      chk(rd_base == m_base[t] && rd_limit == m_limit[t], c != 0 ? "R3 readback" : "R2 readback",
          {rd_limit, rd_base}, {m_limit[t], m_base[t]});
    end
  endtask

  task automatic do_req(input logic [15:0] s, input logic [1:0] c);
    bit loc; logic [16:0] off; logic [31:0] a, lo, hi; logic [1:0] dpl, rpl, epl;
    bit lf, gf, pok; int n, start; logic [63:0] exp_d; logic [3:0] ef, af;
    loc = s[2]; off = {1'b0, s[15:3], 3'b000}; rpl = s[1:0];
    lf = (off + 17'd7) > {1'b0, m_limit[loc]};
    a = m_base[loc] + 32'(off[15:0]);
    lo = mw(a, 0); hi = mw(a + 4, 1);
    exp_d = lf ? 64'd0 : {hi, lo};
    dpl = hi[14:13]; epl = (rpl > dpl) ? rpl : dpl;
    gf = !lf && !loc && !hi[12] && hi[10:9] == 2'b11;
    pok = (c <= dpl) && (epl <= dpl);
    ef = {!lf && !gf && pok, lf, gf, !lf && !gf && !pok};
    @(negedge clk);
    chk(req_ready, "R9 ready when idle", 64'(req_ready), 64'd1);
    start = rd_count;
    req_valid = 1; req_sel = s; req_cpl = c;
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!done && n < 60) begin @(negedge clk); n++; end
    af = {granted, fault_limit, fault_gate, fault_priv};
    chk(done, "R9 done arrives", 64'(done), 64'd1);
    if (lf) chk(af == ef && rd_count == start, "R5 limit fault, no read",
                {32'(rd_count - start), 28'd0, af}, {32'd0, 28'd0, ef});
    else begin
      chk(rd_count - start == 2 && rec1 == a && rec0 == a + 4, "R4 read addresses",
          {rec1, rec0}, {a, a + 32'd4});
      if (gf) chk(af == ef, "R8 gate fault", 64'(af), 64'(ef));
      else chk(af == ef, "R7 privilege decision", 64'(af), 64'(ef));
    end
    chk(desc == exp_d, "R6 descriptor", desc, exp_d);
    @(negedge clk);
    chk(!done && !granted && req_ready, "R9 done single cycle", {done, granted, req_ready}, 64'b001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_base[0] = 0; m_base[1] = 0; m_limit[0] = 0; m_limit[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int t = 0; t < 2; t++) begin
      rd_local = t[0];
      #0.1;
      chk(rd_base == 0 && rd_limit == 0, "R1 reset tables", {rd_limit, rd_base}, 64'd0);
    end
    chk(req_ready && !done && !mem_req, "R1 reset idle", {req_ready, done, mem_req}, 64'b100);

    do_load(0, 32'h0000_1000, 16'hFFFF, 0);
    do_load(1, 32'h0008_0000, 16'h003F, 0);
    do_load(0, 32'hDEAD_0000, 16'h0010, 2);
    do_load(1, 32'hBEEF_0000, 16'h0100, 3);

    force_hi_en = 1;
    force_hi = 32'h0000_6200;
    do_req({13'd7, 1'b1, 2'd0}, 0);
    do_req({13'd8, 1'b1, 2'd0}, 0);
    do_load(1, 32'h0008_0000, 16'h003E, 0);
    do_req({13'd7, 1'b1, 2'd0}, 0);
    do_req({13'd6, 1'b1, 2'd0}, 0);

    force_hi = 32'h0000_6E00;
    do_req({13'd5, 1'b0, 2'd0}, 0);
    do_req({13'd5, 1'b1, 2'd0}, 0);
    force_hi = 32'h0000_6F00;
    do_req({13'd9, 1'b0, 2'd3}, 3);
    force_hi = 32'h0000_1200;
    do_req({13'd1, 1'b0, 2'd3}, 0);
    force_hi = 32'h0000_5200;
    do_req({13'd2, 1'b0, 2'd0}, 3);
    do_req({13'd2, 1'b0, 2'd1}, 2);
    do_req({13'd2, 1'b0, 2'd3}, 2);
    force_hi_en = 0;

    for (int i = 0; i < 300; i++) begin
      salt = $urandom;
      if ($urandom % 8 == 0)
        do_load($urandom % 2, $urandom, 16'($urandom), 2'($urandom % 2 == 0 ? 0 : $urandom % 4));
      do_req(16'($urandom), 2'($urandom));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule